// File: doc/BRIEF.md
# Multi-Game Cartridge Outer Configuration Selector

This block sits at the top of a multi-game cartridge. It watches the CPU write bus. From two write-only configuration registers it decides what the inner hardware presents to the CPU. One decision is whether the start-up menu program or a game fills the 0x8000–0xFFFF window. Another is which of three inner mapper architectures serves that game: a simple 16KB page switcher, a serial-load mapper, or a command/data mapper. It also sets where in the large program ROM the game starts (in 128KB steps), how big the game is, and where its character graphics come from. Graphics come either from a 32KB-granular character ROM bank or from 8KB of writable character RAM.

The first register (0x5001) only holds a pending value. Writing the second register (0x5002) stores that register's own value and commits the pending first value at the same time. The whole mapper architecture therefore changes in one step, never half-configured.

The simple 16KB switcher is built in here because it is small. It translates CPU addresses in the upper window into program-ROM byte addresses, so a simple game runs without further logic. The serial-load and command/data mappers are outside this block and consume its selection outputs.

Top module: `mcsel_top`

## Requirements
- R1: After reset both configuration registers read as zero, so the menu is selected (mode code 0), the program base and character base are 0, character RAM is off, vertical mirroring is not forced and the simple page register holds its second-to-last page (6 with 8 pages).
- R2: A write to 0x5001 by itself changes none of the selection outputs.
- R3: A write to 0x5002 updates all selection outputs, taking the last value written to 0x5001, from the clock edge that accepts the write; with no such write the outputs hold.
- R4: Mode codes on `mapper_mode`: 0x5001 bit 7 clear gives 0 (menu); bit 7 set and bit 6 clear gives 1 (simple switcher); bits 7 and 6 set give 3 (command/data) when 0x5002 bit 4 is set, else 2 (serial-load).
- R5: `prg_base` equals 0x5001 bits 4:0. `game_is_128k` equals 0x5001 bit 5, except in mode 1 where it is always 1.
- R6: `chr_base` equals 0x5002 bits 3:0.
- R7: `chr_ram_sel` is 1 only when 0x5002 holds exactly 0x10 or 0x40. `force_vert` is 1 only for exactly 0x40.
- R8: Writes to 0x5000, 0x5FFF or any other address outside the two registers leave the configuration unchanged.
- R9: `low_win_rom` (0x6000–0x7FFF served from ROM) is 1 exactly when the mode is 0.
- R10: In mode 1, a write anywhere in 0x8000–0xFFFF loads the page register with the data ANDed with (pages − 1). In every other mode such writes are ignored.
- R11: `rom_addr` is {prg_base, page, bus_addr[13:0]}. The page is the page register for 0x8000–0xBFFF and the last page for 0xC000–0xFFFF.
- R12: Every commit through 0x5002 reloads the page register with the second-to-last page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | CPU write strobe, one cycle per write |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| mapper_mode | output | 2 | 0 menu, 1 simple, 2 serial-load, 3 command/data |
| prg_base | output | 5 | Game start in 128KB program-ROM units |
| game_is_128k | output | 1 | 1 for a 128KB game, 0 for 256KB |
| chr_base | output | 4 | Character ROM bank in 32KB units |
| chr_ram_sel | output | 1 | Use 8KB writable character RAM |
| force_vert | output | 1 | Force vertical name-table mirroring |
| low_win_rom | output | 1 | 0x6000 window served from ROM |
| simple_page | output | 3 | Current 16KB page of the simple switcher |
| rom_addr | output | 22 | Program-ROM byte address for the simple switcher |

## Verification
The bench builds the block with its default parameters: a 5-bit program base, a 4-bit character bank, 8 simple pages of 16KB and a 16-bit bus. At that size the full 32-entry base range, the page mask and the top-page forcing can all be reached with real register values. The chosen values drive every bit of the `rom_addr` concatenation. Data values with high bits set above the page mask show that the AND discards them. Near-miss values such as 0x50 and 0x15 check that character RAM is chosen only on an exact match.

// File: rtl/mcsel_pkg.sv
package mcsel_pkg;
  typedef enum logic [1:0] {
    MODE_MENU    = 2'd0,
    MODE_SIMPLE  = 2'd1,
    MODE_SERIAL  = 2'd2,
    MODE_CMDDATA = 2'd3
  } mapper_mode_e;

  // field positions inside the game register (decoded by neighbours)
  localparam int GAME_SEL_BIT  = 7;
  localparam int BANKED_BIT    = 6;
  localparam int SMALL_BIT     = 5;
  // field position inside the graphics register
  localparam int CMDMAP_BIT    = 4;
  localparam logic [7:0] CHR_RAM_CODE_A = 8'h10;
  localparam logic [7:0] CHR_RAM_CODE_B = 8'h40;
endpackage

// File: rtl/mcsel_rst_sync.sv
module mcsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/mcsel_regs.sv
module mcsel_regs #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] GAME_REG = 16'h5001,
  parameter logic [15:0] GFX_REG  = 16'h5002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] game_cfg,
  output logic [DATA_W-1:0] gfx_cfg,
  output logic              commit
);
  logic [DATA_W-1:0] pend_q, pend_d;
  logic [DATA_W-1:0] game_q, game_d;
  logic [DATA_W-1:0] gfx_q,  gfx_d;
  logic              pend_en, commit_en;

  assign pend_en   = bus_we && (bus_addr == ADDR_W'(GAME_REG));
  assign commit_en = bus_we && (bus_addr == ADDR_W'(GFX_REG));

  always_comb begin
    pend_d = pend_q;
    game_d = game_q;
    gfx_d  = gfx_q;
    if (pend_en) pend_d = bus_wdata;
    if (commit_en) begin
      gfx_d  = bus_wdata;
      game_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      game_q <= '0;
      gfx_q  <= '0;
    end else begin
      if (pend_en)   pend_q <= pend_d;
      if (commit_en) begin
        game_q <= game_d;
        gfx_q  <= gfx_d;
      end
    end
  end

  assign game_cfg = game_q;
  assign gfx_cfg  = gfx_q;
  assign commit   = commit_en;
endmodule

// File: rtl/mcsel_decode.sv
module mcsel_decode
  import mcsel_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int GAME_BANK_W = 5,
  parameter int CHR_BANK_W  = 4
) (
  input  logic [DATA_W-1:0]      game_cfg,
  input  logic [DATA_W-1:0]      gfx_cfg,
  output mapper_mode_e           mode,
  output logic [GAME_BANK_W-1:0] prg_base,
  output logic                   game_is_128k,
  output logic [CHR_BANK_W-1:0]  chr_base,
  output logic                   chr_ram_sel,
  output logic                   force_vert,
  output logic                   low_win_rom
);
  always_comb begin
    if (!game_cfg[GAME_SEL_BIT])    mode = MODE_MENU;
    else if (!game_cfg[BANKED_BIT]) mode = MODE_SIMPLE;
    else if (gfx_cfg[CMDMAP_BIT])   mode = MODE_CMDDATA;
    else                            mode = MODE_SERIAL;
  end

  assign prg_base     = game_cfg[GAME_BANK_W-1:0];
  assign game_is_128k = (mode == MODE_SIMPLE) ? 1'b1 : game_cfg[SMALL_BIT];
  assign chr_base     = gfx_cfg[CHR_BANK_W-1:0];
  assign force_vert   = (gfx_cfg == CHR_RAM_CODE_B);
  assign chr_ram_sel  = (gfx_cfg == CHR_RAM_CODE_A) || force_vert;
  assign low_win_rom  = (mode == MODE_MENU);
endmodule

// File: rtl/mcsel_simple.sv
module mcsel_simple
  import mcsel_pkg::*;
#(
  parameter int PAGES = 8,
  localparam int PG_W = $clog2(PAGES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mapper_mode_e    mode,
  input  logic            commit,
  input  logic            bus_we,
  input  logic            upper_win,
  input  logic [PG_W-1:0] wdata_lo,
  output logic [PG_W-1:0] page
);
  localparam logic [PG_W-1:0] START_PAGE = PG_W'(PAGES - 2);

  logic [PG_W-1:0] page_q, page_d;
  logic            load_en;

  assign load_en = commit || (bus_we && upper_win && (mode == MODE_SIMPLE));

  always_comb begin
    page_d = page_q;
    if (commit)       page_d = START_PAGE;
    else if (load_en) page_d = wdata_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= START_PAGE;
    else if (load_en) page_q <= page_d;
  end

  assign page = page_q;
endmodule

// File: rtl/mcsel_top.sv
module mcsel_top
  import mcsel_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          GAME_BANK_W = 5,
  parameter int          CHR_BANK_W  = 4,
  parameter int          PAGES       = 8,
  parameter int          PAGE_LOG2   = 14,
  parameter logic [15:0] GAME_REG    = 16'h5001,
  parameter logic [15:0] GFX_REG     = 16'h5002,
  localparam int PG_W  = $clog2(PAGES),
  localparam int ROM_W = GAME_BANK_W + PG_W + PAGE_LOG2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [1:0]             mapper_mode,
  output logic [GAME_BANK_W-1:0] prg_base,
  output logic                   game_is_128k,
  output logic [CHR_BANK_W-1:0]  chr_base,
  output logic                   chr_ram_sel,
  output logic                   force_vert,
  output logic                   low_win_rom,
  output logic [PG_W-1:0]        simple_page,
  output logic [ROM_W-1:0]       rom_addr
);
  logic              rst_n_s;
  logic [DATA_W-1:0] game_cfg, gfx_cfg;
  logic              commit;
  mapper_mode_e      mode;
  logic [PG_W-1:0]   page_sel;

  mcsel_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  mcsel_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAME_REG(GAME_REG), .GFX_REG(GFX_REG)
  ) regs_i (
    .clk(clk), .rst_n(rst_n_s), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .game_cfg(game_cfg), .gfx_cfg(gfx_cfg), .commit(commit)
  );

  mcsel_decode #(
    .DATA_W(DATA_W), .GAME_BANK_W(GAME_BANK_W), .CHR_BANK_W(CHR_BANK_W)
  ) dec_i (
    .game_cfg(game_cfg), .gfx_cfg(gfx_cfg), .mode(mode), .prg_base(prg_base),
    .game_is_128k(game_is_128k), .chr_base(chr_base), .chr_ram_sel(chr_ram_sel),
    .force_vert(force_vert), .low_win_rom(low_win_rom)
  );

  mcsel_simple #(.PAGES(PAGES)) simple_i (
    .clk(clk), .rst_n(rst_n_s), .mode(mode), .commit(commit), .bus_we(bus_we),
    .upper_win(bus_addr[ADDR_W-1]), .wdata_lo(bus_wdata[PG_W-1:0]), .page(simple_page)
  );

  // the top 16KB of the window is pinned to the last page of the game
  assign page_sel    = bus_addr[PAGE_LOG2] ? {PG_W{1'b1}} : simple_page;
  assign rom_addr    = {prg_base, page_sel, bus_addr[PAGE_LOG2-1:0]};
  assign mapper_mode = mode;
endmodule

// File: rtl/mcsel_chk.sv
module mcsel_chk #(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] GFX_REG     = 16'h5002,
  parameter int          GAME_BANK_W = 5,
  parameter int          CHR_BANK_W  = 4,
  parameter int          PG_W        = 3,
  parameter int          PAGE_LOG2   = 14,
  parameter int          ROM_W       = 22
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_we,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [1:0]             mapper_mode,
  input logic [GAME_BANK_W-1:0] prg_base,
  input logic                   game_is_128k,
  input logic [CHR_BANK_W-1:0]  chr_base,
  input logic                   chr_ram_sel,
  input logic                   force_vert,
  input logic                   low_win_rom,
  input logic [PG_W-1:0]        simple_page,
  input logic [ROM_W-1:0]       rom_addr
);
  logic gfx_wr;
  assign gfx_wr = bus_we && (bus_addr == ADDR_W'(GFX_REG));

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gfx_wr |=> $stable({mapper_mode, prg_base, game_is_128k, chr_base, chr_ram_sel, force_vert}));

  assert_vert_needs_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
    force_vert |-> chr_ram_sel);

  assert_simple_small_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mapper_mode == 2'd1) |-> game_is_128k);

  assert_menu_low_rom_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mapper_mode == 2'd0) |-> low_win_rom);

  assert_page_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mapper_mode != 2'd1) && !gfx_wr) |=> $stable(simple_page));

  assert_top_page_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1] && bus_addr[PAGE_LOG2])
      |-> (rom_addr[PAGE_LOG2 +: PG_W] == {PG_W{1'b1}}));
endmodule

bind mcsel_top mcsel_chk #(
  .ADDR_W(ADDR_W), .GFX_REG(GFX_REG), .GAME_BANK_W(GAME_BANK_W),
  .CHR_BANK_W(CHR_BANK_W), .PG_W(PG_W), .PAGE_LOG2(PAGE_LOG2), .ROM_W(ROM_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .mapper_mode(mapper_mode), .prg_base(prg_base), .game_is_128k(game_is_128k),
  .chr_base(chr_base), .chr_ram_sel(chr_ram_sel), .force_vert(force_vert),
  .low_win_rom(low_win_rom), .simple_page(simple_page), .rom_addr(rom_addr)
);

// File: tb/mcsel_top_tb_top.sv
module mcsel_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [1:0]  mapper_mode;
  logic [4:0]  prg_base;
  logic        game_is_128k;
  logic [3:0]  chr_base;
  logic        chr_ram_sel, force_vert, low_win_rom;
  logic [2:0]  simple_page;
  logic [21:0] rom_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  mcsel_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mapper_mode(mapper_mode), .prg_base(prg_base),
    .game_is_128k(game_is_128k), .chr_base(chr_base), .chr_ram_sel(chr_ram_sel),
    .force_vert(force_vert), .low_win_rom(low_win_rom), .simple_page(simple_page),
    .rom_addr(rom_addr)
  );

  // game reg, graphics reg, mode, 128k flag, chr ram, vertical
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {8'h00, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'h80, 8'h00, 2'd1, 1'b1, 1'b0, 1'b0},
    {8'hC0, 8'h00, 2'd2, 1'b0, 1'b0, 1'b0},
    {8'hC0, 8'h10, 2'd3, 1'b0, 1'b1, 1'b0},
    {8'hE3, 8'h15, 2'd3, 1'b1, 1'b0, 1'b0},
    {8'h9F, 8'h40, 2'd1, 1'b1, 1'b1, 1'b1},
    {8'h5A, 8'h40, 2'd0, 1'b0, 1'b1, 1'b1},
    {8'hC7, 8'h0F, 2'd2, 1'b0, 1'b0, 1'b0},
    {8'hA5, 8'h50, 2'd1, 1'b1, 1'b0, 1'b0},
    {8'hFF, 8'h1F, 2'd3, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 16'h0000; bus_wdata = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    bus_we = 1'b0; bus_addr = 16'h0000; bus_wdata = 8'h00;
    do_reset();

    // R1 / R9 reset state
    check("R1 mode", 32'(mapper_mode), 32'd0);
    check("R1 prg_base", 32'(prg_base), 32'd0);
    check("R1 chr_base", 32'(chr_base), 32'd0);
    check("R1 chr_ram", 32'(chr_ram_sel), 32'd0);
    check("R1 vert", 32'(force_vert), 32'd0);
    check("R1 page", 32'(simple_page), 32'd6);
    check("R9 low rom in menu", 32'(low_win_rom), 32'd1);

    // R3 R4 R5 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] g, c;
      g = VEC[i][20:13];
      c = VEC[i][12:5];
      wr(16'h5001, g);
      wr(16'h5002, c);
      check("R4 mode", 32'(mapper_mode), 32'(VEC[i][4:3]));
      check("R5 size", 32'(game_is_128k), 32'(VEC[i][2]));
      check("R5 base", 32'(prg_base), 32'(g[4:0]));
      check("R6 chr_base", 32'(chr_base), 32'(c[3:0]));
      check("R7 chr ram", 32'(chr_ram_sel), 32'(VEC[i][1]));
      check("R7 vertical", 32'(force_vert), 32'(VEC[i][0]));
      check("R9 low rom", 32'(low_win_rom), 32'(VEC[i][4:3] == 2'd0));
    end

    // R2: pending write alone changes nothing (last commit was 0xFF/0x1F)
    wr(16'h5001, 8'h03);
    check("R2 mode held", 32'(mapper_mode), 32'd3);
    check("R2 base held", 32'(prg_base), 32'h1F);
    // R8: ignored addresses
    wr(16'h5000, 8'h40);
    wr(16'h5FFF, 8'h40);
    wr(16'h4001, 8'hFF);
    check("R8 chr ram untouched", 32'(chr_ram_sel), 32'd0);
    check("R8 chr base untouched", 32'(chr_base), 32'hF);
    // R3: commit takes pending 0x03 (not 0xFF from 0x4001 nor the ignored ones)
    wr(16'h5002, 8'h02);
    check("R3 commit mode", 32'(mapper_mode), 32'd0);
    check("R3 commit base", 32'(prg_base), 32'd3);
    check("R3 commit chr", 32'(chr_base), 32'd2);

    // R10 R11 R12 simple switcher
    wr(16'h8000, 8'h01);
    check("R10 ignored in menu", 32'(simple_page), 32'd6);
    wr(16'h5001, 8'h84);
    wr(16'h5002, 8'h00);
    check("R12 start page", 32'(simple_page), 32'd6);
    @(negedge clk); bus_addr = 16'h8123; #1;
    check("R11 low window", 32'(rom_addr), 32'({5'd4, 3'd6, 14'h0123}));
    bus_addr = 16'hC456; #1;
    check("R11 top window", 32'(rom_addr), 32'({5'd4, 3'd7, 14'h0456}));
    wr(16'h8000, 8'hFD);
    check("R10 masked load", 32'(simple_page), 32'd5);
    @(negedge clk); bus_addr = 16'hA000; #1;
    check("R11 switched page", 32'(rom_addr), 32'({5'd4, 3'd5, 14'h2000}));
    bus_addr = 16'hFFFF; #1;
    check("R11 top pinned", 32'(rom_addr), 32'({5'd4, 3'd7, 14'h3FFF}));
    wr(16'h7FFF, 8'h02);
    check("R10 below window ignored", 32'(simple_page), 32'd5);
    wr(16'h5002, 8'h00);
    check("R12 commit reload", 32'(simple_page), 32'd6);
    wr(16'h5001, 8'hC4);
    wr(16'h5002, 8'h00);
    wr(16'hE000, 8'h03);
    check("R10 ignored in serial", 32'(simple_page), 32'd6);

    // R1 reset mid-run
    do_reset();
    check("R1 mode after rerun", 32'(mapper_mode), 32'd0);
    check("R1 base after rerun", 32'(prg_base), 32'd0);
    wr(16'h5002, 8'h00);
    check("R1 pending cleared", 32'(mapper_mode), 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule